// File: doc/BRIEF.md
# MSI capability and message generator

This block implements a four-dword configuration-space capability structure for message signaled interrupts, together with the engine that sends the message. Software uses a 32-bit, dword-indexed register port to read the capability header and to program the enable bit, the multiple-message-enabled field, a 64-bit message address and a 16-bit message data word. Register reads are combinational on the index.

An internal interrupt source feeds the block. While the enable bit is clear, the source level drives a registered legacy interrupt line. While the enable bit is set, the legacy line stays low. Each rising edge of the source then becomes one posted memory-write request on a valid/ready port. The request carries the message data and the programmed address. If an edge arrives while a request is still stalled, the block remembers it with a single pending flag. It then issues exactly one more write after the stalled one is accepted.

Top module: `msi_cap_top`

## Requirements
- R1: After reset, dword index 0 reads 0x0080_AC05 with the default next pointer 0xAC: capability ID 0x05 in bits 7:0, next pointer in bits 15:8, message control in bits 31:16 (enable = bit 16, capable field = bits 19:17, enabled field = bits 22:20, 64-bit capable = bit 23).
- R2: In dword 0, only the enable bit and the enabled field are writable. Writing 0xFFFF_FFFF reads back 0x00F1_AC05, and writing 0 reads back 0x0080_AC05.
- R3: Dword index 1 holds the lower address, and its bits 1:0 always read zero. Dword index 2 holds the upper address, fully writable.
- R4: Dword index 3 holds the message data in bits 15:0, and bits 31:16 read zero.
- R5: With MSI disabled, the legacy line follows the source level one clock later, and no write request is made.
- R6: With MSI enabled, each rising edge of the source produces exactly one write request. The request carries address {upper, lower} and data {16'h0, message data}, and the legacy line stays low.
- R7: The write data is little-endian: wr_data[7:0] is the byte at the lowest address. So data 0xCAFE appears as bytes FE CA 00 00.
- R8: wr_is64 is 0 when the upper address is zero and 1 otherwise.
- R9: Edges that arrive while a request is stalled produce exactly one further write, taken from the register contents at the time it is issued. Multiple stalled edges do not queue multiple copies.
- R10: A request keeps wr_valid high, and keeps its address and data stable, until wr_ready is high.
- R11: Clearing the enable bit returns later events to the legacy line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_idx | input | 2 | Dword index within the capability |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_idx |
| irq_src | input | 1 | Internal interrupt source level |
| intx_o | output | 1 | Legacy level interrupt line |
| wr_valid | output | 1 | Memory-write request valid |
| wr_ready | input | 1 | Memory-write request accepted |
| wr_addr | output | 64 | Message address |
| wr_data | output | 32 | Message dword |
| wr_is64 | output | 1 | Request uses a 64-bit address |

## Verification
The hardest case to reach is coalescing. It needs several source edges to land while one request is held by a low ready, and the message data must change in between. The stimulus holds wr_ready low and pulses the source three times, rewriting the data register after the first pulse. It then releases ready. The scoreboard must see exactly two writes: the first with the old data and the second with the new data.

// File: rtl/msi_pkg.sv
package msi_pkg;
    localparam int unsigned MSG_W  = 16;
    localparam int unsigned DW     = 32;
    localparam int unsigned AW     = 64;
    localparam int unsigned ALO_W  = DW - 2;
    localparam logic [7:0]  CAP_ID = 8'h05;

    typedef enum logic [1:0] {
        IDX_HDR  = 2'd0,
        IDX_ALO  = 2'd1,
        IDX_AHI  = 2'd2,
        IDX_DATA = 2'd3
    } reg_idx_e;

    typedef struct packed {
        logic             en;
        logic [2:0]       mme;
        logic [ALO_W-1:0] addr_lo;
        logic [DW-1:0]    addr_hi;
        logic [MSG_W-1:0] data;
    } msi_cfg_t;

    typedef struct packed {
        logic          src;
        logic          valid;
        logic          pend;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic          is64;
    } eng_st_t;
endpackage

// File: rtl/msi_regs.sv
module msi_regs
    import msi_pkg::*;
#(
    parameter logic [7:0] NEXT_PTR = 8'hAC
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    idx,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output msi_cfg_t      cfg
);
    localparam logic [2:0] MMC_FIXED = 3'b000;
    localparam int unsigned PAD_W = DW - MSG_W;

    msi_cfg_t cfg_d, cfg_q;
    logic unused_wbits;

    assign unused_wbits = ^wdata;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            case (reg_idx_e'(idx))
                IDX_HDR: begin
                    cfg_d.en  = wdata[16];
                    cfg_d.mme = wdata[22:20];
                end
                IDX_ALO:  cfg_d.addr_lo = wdata[DW-1:2];
                IDX_AHI:  cfg_d.addr_hi = wdata;
                IDX_DATA: cfg_d.data    = wdata[MSG_W-1:0];
                default:  cfg_d = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        case (reg_idx_e'(idx))
            IDX_HDR:  rdata = {8'h00, 1'b1, cfg_q.mme, MMC_FIXED, cfg_q.en, NEXT_PTR, CAP_ID};
            IDX_ALO:  rdata = {cfg_q.addr_lo, 2'b00};
            IDX_AHI:  rdata = cfg_q.addr_hi;
            default:  rdata = {{PAD_W{1'b0}}, cfg_q.data};
        endcase
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/msi_legacy.sv
module msi_legacy (
    input  logic clk,
    input  logic rst_n,
    input  logic src_i,
    input  logic en_i,
    output logic intx_o
);
    logic intx_d, intx_q;

    always_comb intx_d = src_i & ~en_i;

    always_ff @(posedge clk) begin
        if (!rst_n) intx_q <= 1'b0;
        else        intx_q <= intx_d;
    end

    assign intx_o = intx_q;
endmodule

// File: rtl/msi_engine.sv
module msi_engine
    import msi_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  msi_cfg_t      cfg,
    input  logic          src_i,
    output logic          valid_o,
    input  logic          ready_i,
    output logic [AW-1:0] addr_o,
    output logic [DW-1:0] data_o,
    output logic          is64_o
);
    localparam int unsigned PAD_W = DW - MSG_W;

    eng_st_t st_d, st_q;
    logic    fire;
    logic    accept;

    always_comb begin
        st_d     = st_q;
        st_d.src = src_i;
        fire     = src_i & ~st_q.src & cfg.en;
        accept   = st_q.valid & ready_i;
        if (st_q.valid && !accept) begin
            // stalled: remember at most one further event
            if (fire) st_d.pend = 1'b1;
        end else if (fire || (st_q.pend && cfg.en)) begin
            st_d.valid = 1'b1;
            st_d.pend  = 1'b0;
            st_d.addr  = {cfg.addr_hi, cfg.addr_lo, 2'b00};
            st_d.data  = {{PAD_W{1'b0}}, cfg.data};
            st_d.is64  = (cfg.addr_hi != '0);
        end else begin
            st_d.valid = 1'b0;
            st_d.pend  = 1'b0;
        end
        if (!cfg.en && !(st_q.valid && !accept)) st_d.pend = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid_o = st_q.valid;
    assign addr_o  = st_q.addr;
    assign data_o  = st_q.data;
    assign is64_o  = st_q.is64;
endmodule

// File: rtl/msi_cap_top.sv
module msi_cap_top
    import msi_pkg::*;
#(
    parameter logic [7:0] NEXT_PTR = 8'hAC
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr,
    input  logic [1:0]    cfg_idx,
    input  logic [DW-1:0] cfg_wdata,
    output logic [DW-1:0] cfg_rdata,
    input  logic          irq_src,
    output logic          intx_o,
    output logic          wr_valid,
    input  logic          wr_ready,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          wr_is64
);
    msi_cfg_t cfg;

    msi_regs #(.NEXT_PTR(NEXT_PTR)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .idx(cfg_idx),
        .wdata(cfg_wdata), .rdata(cfg_rdata), .cfg(cfg)
    );

    msi_legacy u_legacy (
        .clk(clk), .rst_n(rst_n), .src_i(irq_src), .en_i(cfg.en), .intx_o(intx_o)
    );

    msi_engine u_engine (
        .clk(clk), .rst_n(rst_n), .cfg(cfg), .src_i(irq_src),
        .valid_o(wr_valid), .ready_i(wr_ready), .addr_o(wr_addr),
        .data_o(wr_data), .is64_o(wr_is64)
    );
endmodule

// File: rtl/msi_chk.sv
module msi_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        msi_en,
    input logic        intx_o,
    input logic        wr_valid,
    input logic        wr_ready,
    input logic [63:0] wr_addr,
    input logic [31:0] wr_data,
    input logic        wr_is64
);
    // R10
    hold_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !wr_ready |=> wr_valid);
    // R10
    hold_payload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !wr_ready |=> $stable(wr_addr) && $stable(wr_data));
    // R3
    addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> wr_addr[1:0] == 2'b00);
    // R4
    data_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> wr_data[31:16] == 16'h0);
    // R8
    width_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> wr_is64 == (wr_addr[63:32] != 32'h0));
    // R6
    legacy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        intx_o |-> !$past(msi_en));
endmodule

bind msi_cap_top msi_chk u_chk (
    .clk(clk), .rst_n(rst_n), .msi_en(cfg.en), .intx_o(intx_o),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_is64(wr_is64)
);

// File: tb/sim_msi_cap_top.sv
`timescale 1ns/1ps
module sim_msi_cap_top;
    typedef struct packed {
        logic [63:0] addr;
        logic [31:0] data;
        logic        is64;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_idx = 2'd0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        irq_src = 1'b0;
    logic        intx_o;
    logic        wr_valid;
    logic        wr_ready = 1'b1;
    logic [63:0] wr_addr;
    logic [31:0] wr_data;
    logic        wr_is64;

    int   errors = 0;
    int   checks = 0;
    int   nwr = 0;
    bit   done = 1'b0;
    exp_t expq[$];

    always #4 clk = ~clk;

    msi_cap_top u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq_src(irq_src),
        .intx_o(intx_o), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_is64(wr_is64)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wreg(input logic [1:0] idx, input logic [31:0] v);
        cfg_wr = 1'b1; cfg_idx = idx; cfg_wdata = v;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic rreg(input logic [1:0] idx, output logic [31:0] v);
        cfg_idx = idx;
        #1 v = cfg_rdata;
    endtask

    task automatic pulse();
        irq_src = 1'b1;
        @(negedge clk);
        irq_src = 1'b0;
        @(negedge clk);
    endtask

    task automatic expect_wr(input logic [63:0] a, input logic [15:0] d);
        exp_t e;
        e.addr = a; e.data = {16'h0, d}; e.is64 = (a[63:32] != 0);
        expq.push_back(e);
    endtask

    // monitor: a request is taken at the edge following a sample with valid and ready
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (rst_n && wr_valid && wr_ready) begin
                nwr++;
                if (expq.size() == 0) begin
                    chk("R6 unexpected write", wr_addr, 64'h0);
                end else begin
                    exp_t e;
                    e = expq.pop_front();
                    chk("R6 address", wr_addr, e.addr);
                    chk("R7 data", {32'h0, wr_data}, {32'h0, e.data});
                    chk("R8 width flag", {63'h0, wr_is64}, {63'h0, e.is64});
                end
            end
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int n0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset header
        rreg(2'd0, v); chk("R1 header reset", {32'h0, v}, 64'h0080AC05);
        chk("R1 no request", {63'h0, wr_valid}, 64'h0);
        chk("R1 legacy low", {63'h0, intx_o}, 64'h0);

        // R2 read-only fields
        wreg(2'd0, 32'hFFFF_FFFF);
        rreg(2'd0, v); chk("R2 header all ones", {32'h0, v}, 64'h00F1AC05);
        wreg(2'd0, 32'h0);
        rreg(2'd0, v); chk("R2 header cleared", {32'h0, v}, 64'h0080AC05);

        // R3 address registers
        wreg(2'd1, 32'h1D96_2903);
        rreg(2'd1, v); chk("R3 lower aligned", {32'h0, v}, 64'h1D962900);
        wreg(2'd2, 32'hFFFF_FFFF);
        rreg(2'd2, v); chk("R3 upper", {32'h0, v}, 64'hFFFFFFFF);
        wreg(2'd2, 32'h0);

        // R4 data register
        wreg(2'd3, 32'h1234_CAFE);
        rreg(2'd3, v); chk("R4 data", {32'h0, v}, 64'h0000CAFE);

        // R5 legacy mode
        n0 = nwr;
        irq_src = 1'b1;
        @(negedge clk);
        chk("R5 legacy high", {63'h0, intx_o}, 64'h1);
        irq_src = 1'b0;
        @(negedge clk);
        chk("R5 legacy follows low", {63'h0, intx_o}, 64'h0);
        repeat (2) @(negedge clk);
        chk("R5 no write", nwr, n0);

        // R6 R7 R8 enabled, 32-bit address
        wreg(2'd0, 32'h0001_0000);
        expect_wr(64'h0000_0000_1D96_2900, 16'hCAFE);
        irq_src = 1'b1;
        @(negedge clk);
        chk("R6 legacy stays low", {63'h0, intx_o}, 64'h0);
        #1 chk("R7 low byte FE", {56'h0, wr_data[7:0]}, 64'hFE);
        chk("R7 second byte CA", {56'h0, wr_data[15:8]}, 64'hCA);
        irq_src = 1'b0;
        repeat (3) @(negedge clk);
        chk("R6 one write", nwr, n0 + 1);

        // R8 64-bit address
        wreg(2'd2, 32'h0000_0001);
        expect_wr(64'h0000_0001_1D96_2900, 16'hCAFE);
        pulse();
        repeat (2) @(negedge clk);
        chk("R8 queue drained", expq.size(), 0);

        // R9 R10 coalescing under back-pressure
        n0 = nwr;
        wr_ready = 1'b0;
        expect_wr(64'h0000_0001_1D96_2900, 16'hCAFE);
        pulse();
        wreg(2'd3, 32'h0000_BEEF);
        expect_wr(64'h0000_0001_1D96_2900, 16'hBEEF);
        pulse();
        pulse();
        #1 chk("R10 still valid", {63'h0, wr_valid}, 64'h1);
        chk("R10 payload held", {32'h0, wr_data}, 64'h0000CAFE);
        @(negedge clk);
        wr_ready = 1'b1;
        repeat (6) @(negedge clk);
        chk("R9 exactly two writes", nwr, n0 + 2);
        chk("R9 queue drained", expq.size(), 0);

        // R11 disable returns to legacy
        n0 = nwr;
        wreg(2'd0, 32'h0);
        irq_src = 1'b1;
        @(negedge clk);
        chk("R11 legacy high", {63'h0, intx_o}, 64'h1);
        irq_src = 1'b0;
        repeat (3) @(negedge clk);
        chk("R11 no write", nwr, n0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule